// File: doc/BRIEF.md
# Offset-Search Sweep Test Controller

This block runs an on-chip self-characterization sweep over an array of sense-amplifier test cells. It selects one cell at a time and drives a step code to an external voltage-step generator, which sets the input differential of that cell. For each step it first holds the sense-enable low so the cell precharges. It then raises the sense-enable for a long, programmable window and samples the cell's single output bit at the end of that window.

An output of 1 means the sense failed. The controller then raises the step code by one and repeats the measurement on the same cell. An output of 0 means the sense passed, and the current code is written into a result memory at the cell's address. The controller then moves to the next cell with the code back at zero. If a cell still fails at the largest code, an all-ones code with an overflow flag is stored for it. Cells with larger mismatch need more steps, so a running count of sense steps reports the total characterization time.

The address is split into a row field (upper bits) and a column field (lower bits). The sense-enable reaches only the selected row, and only the selected column has its differential inputs driven. All other columns are held at 0.

Top module: `offs_sweep_ctrl`

## Requirements
- R1: After reset, and while idle, busy, done, res_we, every row_sae bit and every col_drive bit are 0, and step_total is 0 after reset.
- R2: A start pulse while idle begins a sweep at address 0 with step code 0 and clears step_total. A start pulse while busy has no effect on the sequence of writes.
- R3: row_sae has at most one bit set, and that bit is the row given by cell_addr[ROW_W+COL_W-1:COL_W]. While busy, col_drive is one-hot at the column cell_addr[COL_W-1:0]. While idle, col_drive is all 0.
- R4: Each step takes PRE_CYC cycles with row_sae low, then exactly SENSE_CYC cycles with row_sae high, then one evaluate cycle. cell_out is sampled in the last sense cycle.
- R5: A sampled 1 below the largest code raises step_code by one, and the same cell is measured again.
- R6: A sampled 0 writes res_data = {1'b0, step_code} at res_addr = cell_addr with res_we high for one cycle. The next cell then starts with step_code 0. Cells are visited in increasing address order.
- R7: A sampled 1 at the largest code (all ones) writes res_data = {1'b1, all ones}, where bit CODE_W is the overflow flag. The sweep then continues with the next cell.
- R8: After the write for the last address, done is high for exactly one cycle, the cycle right after that write, and busy is low in that cycle.
- R9: step_total counts every sense sample taken since the last accepted start, and holds its value after the sweep ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep (taken only while idle) |
| cell_out | input | 1 | Output bit of the selected test cell |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse after the final write |
| row_sae | output | 2**ROW_W | Per-row sense-enable, gated to the selected row |
| col_drive | output | 2**COL_W | Per-column input enable; low columns hold their inputs at 0 |
| cell_addr | output | ROW_W+COL_W | Address of the cell under test |
| step_code | output | CODE_W | Differential step code to the voltage-step generator |
| res_we | output | 1 | Result memory write strobe |
| res_addr | output | ROW_W+COL_W | Result memory write address |
| res_data | output | CODE_W+1 | {overflow flag, code} |
| step_total | output | TOT_W | Total sense steps used in the sweep |

## Verification
A start edge puts the block into precharge on that edge. Every step then lasts PRE_CYC+SENSE_CYC+1 cycles, and the result write is visible during the evaluate cycle, which is the last cycle of the step. done follows one cycle after the last write. The bench therefore predicts the number of busy cycles per sweep as the sum over cells of (steps × (PRE_CYC+SENSE_CYC+1)), where a cell needs min(threshold, max code)+1 steps. The bench samples every output on the falling edge so that each registered change is seen in the cycle it is due. Three sweeps run over a small 16-cell, 3-bit-code array with mixed, all-zero and all-saturating thresholds, and one start pulse is injected while busy.

// File: rtl/offs_pkg.sv
package offs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRE   = 2'd1,
        ST_SENSE = 2'd2,
        ST_EVAL  = 2'd3
    } sweep_state_e;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/offs_phase_timer.sv
module offs_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R4: a loaded value is taken on the next cycle
    assert_timer_load_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(load_val));
endmodule

// File: rtl/offs_sel_decode.sv
module offs_sel_decode #(
    parameter int SEL_W = 4
) (
    input  logic                  en,
    input  logic [SEL_W-1:0]      idx,
    output logic [(1<<SEL_W)-1:0] line
);
    localparam int N = 1 << SEL_W;

    for (genvar g = 0; g < N; g++) begin : g_line
        assign line[g] = en && (idx == SEL_W'(g));
    end

    always_comb begin
        assert_sel_onehot_R3: assert ($onehot0(line));
        if (!en) assert_sel_quiet_R3: assert (line == '0);
    end
endmodule

// File: rtl/offs_step_count.sv
module offs_step_count #(
    parameter int TOT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [TOT_W-1:0] total
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            total <= '0;
        else if (inc)
            total <= total + 1'b1;
    end

    assert_total_inc_R9: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> total == $past(total) + 1'b1);
    assert_total_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(total));
endmodule

// File: rtl/offs_sweep_ctrl.sv
module offs_sweep_ctrl
    import offs_pkg::*;
#(
    parameter int ROW_W     = 5,
    parameter int COL_W     = 4,
    parameter int CODE_W    = 6,
    parameter int PRE_CYC   = 4,
    parameter int SENSE_CYC = 64,
    parameter int TOT_W     = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    cell_out,
    output logic                    busy,
    output logic                    done,
    output logic [(1<<ROW_W)-1:0]   row_sae,
    output logic [(1<<COL_W)-1:0]   col_drive,
    output logic [ROW_W+COL_W-1:0]  cell_addr,
    output logic [CODE_W-1:0]       step_code,
    output logic                    res_we,
    output logic [ROW_W+COL_W-1:0]  res_addr,
    output logic [CODE_W:0]         res_data,
    output logic [TOT_W-1:0]        step_total
);
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int TMAX   = int'(max_of(PRE_CYC, SENSE_CYC));
    localparam int CNT_W  = $clog2(TMAX + 1);
    localparam logic [CODE_W-1:0] CODE_MAX  = '1;
    localparam logic [ADDR_W-1:0] ADDR_LAST = '1;
    localparam logic [CNT_W-1:0]  PRE_LD    = CNT_W'(PRE_CYC - 1);
    localparam logic [CNT_W-1:0]  SENSE_LD  = CNT_W'(SENSE_CYC - 1);

    sweep_state_e      state;
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] code;
    logic              sample;
    logic              done_q;
    logic              t_load;
    logic [CNT_W-1:0]  t_val;
    logic              t_zero;
    logic              retry;

    assign retry = sample && (code != CODE_MAX);

    always_comb begin
        t_load = 1'b0;
        t_val  = PRE_LD;
        unique case (state)
            ST_IDLE:  t_load = start;
            ST_PRE:   begin t_load = t_zero; t_val = SENSE_LD; end
            ST_SENSE: t_load = 1'b0;
            ST_EVAL:  t_load = retry || (addr != ADDR_LAST);
            default:  t_load = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            addr   <= '0;
            code   <= '0;
            sample <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_PRE;
                    addr  <= '0;
                    code  <= '0;
                end
                ST_PRE: if (t_zero) state <= ST_SENSE;
                ST_SENSE: if (t_zero) begin
                    sample <= cell_out;
                    state  <= ST_EVAL;
                end
                ST_EVAL: begin
                    if (retry) begin
                        code  <= code + 1'b1;
                        state <= ST_PRE;
                    end else begin
                        code <= '0;
                        if (addr == ADDR_LAST) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            addr  <= addr + 1'b1;
                            state <= ST_PRE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    offs_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_zero)
    );

    offs_sel_decode #(.SEL_W(ROW_W)) u_row (
        .en(state == ST_SENSE), .idx(addr[ADDR_W-1:COL_W]), .line(row_sae)
    );

    offs_sel_decode #(.SEL_W(COL_W)) u_col (
        .en(state != ST_IDLE), .idx(addr[COL_W-1:0]), .line(col_drive)
    );

    offs_step_count #(.TOT_W(TOT_W)) u_count (
        .clk(clk), .rst(rst),
        .clr(state == ST_IDLE && start),
        .inc(state == ST_SENSE && t_zero),
        .total(step_total)
    );

    assign busy      = (state != ST_IDLE);
    assign done      = done_q;
    assign cell_addr = addr;
    assign step_code = code;
    assign res_we    = (state == ST_EVAL) && !retry;
    assign res_addr  = addr;
    assign res_data  = {sample, code};

    assert_sae_in_sense_R4: assert property (@(posedge clk) disable iff (rst)
        (row_sae != '0) |-> busy && !res_we);
    assert_retry_step_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !res_we && state == ST_EVAL) |=> step_code == $past(step_code) + 1'b1);
    assert_code_reset_R6: assert property (@(posedge clk) disable iff (rst)
        res_we |=> step_code == '0);
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (res_we && res_data[CODE_W]) |-> res_data[CODE_W-1:0] == CODE_MAX);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && $past(res_we) && $past(res_addr) == ADDR_LAST);
    assert_busy_start_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy && cell_addr == '0 && step_code == '0);
endmodule

// File: tb/tb_offs_sweep_ctrl.sv
module tb_offs_sweep_ctrl;
    localparam int ROW_W = 2, COL_W = 2, CODE_W = 3;
    localparam int PRE_CYC = 2, SENSE_CYC = 5, TOT_W = 12;
    localparam int CELLS = 1 << (ROW_W + COL_W);
    localparam int CMAX  = (1 << CODE_W) - 1;
    localparam int STEP_CYC = PRE_CYC + SENSE_CYC + 1;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, cell_out;
    logic busy, done, res_we;
    logic [(1<<ROW_W)-1:0] row_sae;
    logic [(1<<COL_W)-1:0] col_drive;
    logic [ROW_W+COL_W-1:0] cell_addr, res_addr, prev_addr;
    logic [CODE_W-1:0] step_code;
    logic [CODE_W:0] res_data;
    logic [TOT_W-1:0] step_total;

    int checks = 0, fails = 0, mode = 0, exp_idx = 0, busy_cyc = 0, done_cnt = 0, sae_run = 0;
    int cyc = 0;
    bit monitor_on = 0;

    always #4 clk = ~clk;

    offs_sweep_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .CODE_W(CODE_W), .PRE_CYC(PRE_CYC),
        .SENSE_CYC(SENSE_CYC), .TOT_W(TOT_W)) dut (
        .clk(clk), .rst(rst), .start(start), .cell_out(cell_out), .busy(busy), .done(done),
        .row_sae(row_sae), .col_drive(col_drive), .cell_addr(cell_addr), .step_code(step_code),
        .res_we(res_we), .res_addr(res_addr), .res_data(res_data), .step_total(step_total));

    function automatic int thr(input int m, input int i);
        if (m == 0) return (i * 5 + 3) % (CMAX + 3);
        if (m == 1) return 0;
        return CMAX + 2;
    endfunction

    function automatic int cell_steps(input int m, input int i);
        return (thr(m, i) > CMAX) ? CMAX + 1 : thr(m, i) + 1;
    endfunction

    // cell model: fails while code is below its threshold; reads 1 unless being sensed
    always_comb begin
        if (row_sae[cell_addr[ROW_W+COL_W-1:COL_W]] && col_drive[cell_addr[COL_W-1:0]])
            cell_out = (int'(step_code) < thr(mode, int'(cell_addr)));
        else
            cell_out = 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
        if (monitor_on) begin
            if (busy) busy_cyc++;
            if (done) begin
                done_cnt++;
                check(!busy, "R8 busy at done", int'(busy), 0);
            end
            if (res_we) begin
                check(int'(res_addr) == exp_idx, "R6 write addr", int'(res_addr), exp_idx);
                if (thr(mode, exp_idx) > CMAX)
                    check(res_data == {1'b1, {CODE_W{1'b1}}}, "R7 saturated word",
                          int'(res_data), (1 << (CODE_W + 1)) - 1);
                else
                    check(int'(res_data) == thr(mode, exp_idx), "R6 pass code",
                          int'(res_data), thr(mode, exp_idx));
                exp_idx++;
            end
            if (busy) begin
                check(col_drive == (1 << cell_addr[COL_W-1:0]), "R3 column drive",
                      int'(col_drive), 1 << cell_addr[COL_W-1:0]);
                check(row_sae == '0 || row_sae == (1 << cell_addr[ROW_W+COL_W-1:COL_W]),
                      "R3 row gating", int'(row_sae), 1 << cell_addr[ROW_W+COL_W-1:COL_W]);
                if (cell_addr != prev_addr)
                    check(step_code == '0, "R6 code restart", int'(step_code), 0);
            end else begin
                check(col_drive == '0 && row_sae == '0, "R3 idle quiet",
                      int'(col_drive) + int'(row_sae), 0);
            end
            if (row_sae != '0) sae_run++;
            else if (sae_run != 0) begin
                check(sae_run == SENSE_CYC, "R4 sense window", sae_run, SENSE_CYC);
                sae_run = 0;
            end
            prev_addr = cell_addr;
        end
    end

    task automatic run_sweep(input int m, input bit poke);
        int exp_tot = 0;
        mode = m; exp_idx = 0; busy_cyc = 0; done_cnt = 0; sae_run = 0;
        for (int i = 0; i < CELLS; i++) exp_tot += cell_steps(m, i);
        @(negedge clk); start = 1'b1; prev_addr = '0;
        @(negedge clk); start = 1'b0;
        check(busy && cell_addr == '0 && step_code == '0, "R2 start state",
              int'(cell_addr) + int'(step_code), 0);
        if (poke) begin
            repeat (40) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;   // R2: ignored while busy
        end
        while (done_cnt == 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_idx == CELLS, "R6 write count", exp_idx, CELLS);
        check(busy_cyc == exp_tot * STEP_CYC, "R4 sweep duration", busy_cyc, exp_tot * STEP_CYC);
        check(done_cnt == 1, "R8 single done", done_cnt, 1);
        check(int'(step_total) == exp_tot, "R9 step total", int'(step_total), exp_tot);
        repeat (5) @(negedge clk);
        check(int'(step_total) == exp_tot, "R9 total held", int'(step_total), exp_tot);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !res_we && row_sae == '0 && col_drive == '0 && step_total == '0,
              "R1 reset state", int'(busy) + int'(done) + int'(res_we), 0);
        monitor_on = 1;
        run_sweep(0, 1'b1);   // mixed thresholds, R5 retries, R7 saturation, R2 mid-run start
        run_sweep(1, 1'b0);   // all cells pass on first sense
        run_sweep(2, 1'b0);   // every cell saturates (R7)
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule